// File: doc/BRIEF.md
# Banked Vector Memory Address Generator

This block turns one vector memory command into a sequence of per-element accesses on a memory split into several banks. The banks share one row bus and one write-data bus, and each has its own request strobe. A command picks one of two addressing modes. In the strided mode the element address steps from a base by a fixed stride. In the indexed mode it is the base plus a per-element offset taken from an index vector, which gives gather on loads and scatter on stores. Each address is split into a bank number and a row within that bank.

Elements go out in index order, at most one per cycle. Each bank stays busy for a fixed number of cycles after it accepts an access. An element whose bank is still busy waits, and every later element waits behind it. A stride that shares no factor with the bank count therefore keeps one element per cycle flowing. A stride such as the bank count itself puts every element on one bank. Load responses come back from the banks and are written out tagged with their element number. A one-cycle done pulse closes each command.

The command port is valid/ready: a command is taken on a cycle with `cmd_valid` and `cmd_ready` both high, and `cmd_ready` stays low until the command finishes. Store data is a valid/ready stream with one beat per element in element order. A beat is consumed only on a cycle where the element is sent to its bank. The source may hold `wd_valid` low for any time, and the element then waits. The bank request strobes and the load writeback carry no ready. The banks and the writeback consumer must accept what they are given.

Top module: `vec_agu`

## Requirements
- R1: In strided mode (`cmd_indexed`=0) element i uses address (base + i*stride) mod 2^ADDR_W. The stride is two's complement, so 16'hFFFF steps downward. The bank is the address's low log2(NB) bits (address mod NB) and is shown as the one-hot bit in `bank_sel`. `bus_row` carries the remaining upper bits.
- R2: In indexed mode (`cmd_indexed`=1) element i uses address base + `idx_vec[i*ADDR_W +: ADDR_W]`, captured when the command is taken, for both loads and stores, with the same bank/row split as R1.
- R3: At most one bit of `bank_sel` is high in any cycle. Elements go out in ascending index order and `bus_tag` carries the element index.
- R4: A bank that received a request in cycle t receives no other request before cycle t+LAT.
- R5: No needless stall. Element 0 goes out in the first cycle after the command is taken. Element i goes out in the earliest cycle that is after element i-1, at least LAT cycles after the last request to its bank, and (for stores) a cycle with store data valid.
- R6: For a store (`cmd_store`=1) every request has `bus_we`=1 and carries the next store-data beat. `wd_ready` is high only in a cycle where the element can go out. No request is sent while `wd_valid` is low.
- R7: A load response on bank b appears on `ld_valid`/`ld_idx`/`ld_data` one cycle later, with the response's tag and data.
- R8: `done` is high for exactly one cycle per command. For a store it comes two cycles after the last request. For a load it comes one cycle after the last writeback.
- R9: `cmd_ready` is high only while no command is in progress. A command of length 0 sends no request and raises `done` in the second cycle after it is taken.
- R10: During and straight after reset `cmd_ready`=1, `bank_sel`=0, `done`=0 and `ld_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command accepted this cycle if valid |
| cmd_indexed | input | 1 | 0 strided, 1 indexed |
| cmd_store | input | 1 | 0 load, 1 store |
| cmd_base | input | ADDR_W | Base address |
| cmd_stride | input | ADDR_W | Element stride (strided mode) |
| cmd_len | input | LEN_W | Element count, 0..MAX_VL |
| idx_vec | input | MAX_VL*ADDR_W | Per-element offsets (indexed mode) |
| wd_valid | input | 1 | Store data beat valid |
| wd_ready | output | 1 | Store data beat consumed |
| wd_data | input | DATA_W | Store data beat |
| bank_sel | output | NB | One-hot request strobe per bank |
| bus_we | output | 1 | Shared write enable |
| bus_row | output | ROW_W | Shared row within bank |
| bus_wdata | output | DATA_W | Shared write data |
| bus_tag | output | TAG_W | Element index of the request |
| bank_rsp_valid | input | NB | Per-bank load response valid |
| bank_rsp_data | input | NB*DATA_W | Per-bank response data |
| bank_rsp_tag | input | NB*TAG_W | Per-bank response tag |
| ld_valid | output | 1 | Load writeback valid |
| ld_idx | output | TAG_W | Writeback element index |
| ld_data | output | DATA_W | Writeback data |
| done | output | 1 | One-cycle command completion pulse |

## Verification
The bench aims at bank timing. It runs a stride of 2 on four banks, which must stall every other pair of elements, a stride equal to the bank count, which must space each element LAT cycles apart, and a stride of 3, which must run at full rate. A design that ignored the busy window would hit a bank too early. One that stalled on the wrong bank would lose cycles that the expected issue times expose. It also covers a downward stride that wraps through zero, a gather and a scatter whose offsets collide in one bank, a store stream that starts late (any early request or wrong beat shows), and a zero-length command that must still finish.

// File: rtl/vagu_pkg.sv
`timescale 1ns/1ps
package vagu_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_WAIT = 2'd2
  } vagu_state_e;
endpackage

// File: rtl/vagu_addr_gen.sv
`timescale 1ns/1ps
module vagu_addr_gen #(
  parameter int ADDR_W = 16,
  parameter int MAX_VL = 16,
  localparam int TAG_W = $clog2(MAX_VL)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic                     step,
  input  logic                     indexed,
  input  logic [ADDR_W-1:0]        base,
  input  logic [ADDR_W-1:0]        stride,
  input  logic [MAX_VL*ADDR_W-1:0] offsets,
  input  logic [TAG_W-1:0]         elem,
  output logic [ADDR_W-1:0]        addr
);
  logic              indexed_q;
  logic [ADDR_W-1:0] base_q;
  logic [ADDR_W-1:0] stride_q;
  logic [ADDR_W-1:0] acc_q;
  logic [ADDR_W-1:0] off_q [MAX_VL];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      indexed_q <= 1'b0;
      base_q    <= '0;
      stride_q  <= '0;
      acc_q     <= '0;
      for (int i = 0; i < MAX_VL; i++) off_q[i] <= '0;
    end else if (start) begin
      indexed_q <= indexed;
      base_q    <= base;
      stride_q  <= stride;
      acc_q     <= '0;
      for (int i = 0; i < MAX_VL; i++) off_q[i] <= offsets[i*ADDR_W +: ADDR_W];
    end else if (step) begin
      acc_q <= acc_q + stride_q;
    end
  end

  assign addr = indexed_q ? (base_q + off_q[elem]) : (base_q + acc_q);
endmodule

// File: rtl/vagu_bank_busy.sv
`timescale 1ns/1ps
module vagu_bank_busy #(
  parameter int NB  = 4,
  parameter int LAT = 4,
  localparam int CNT_W = (LAT > 1) ? $clog2(LAT) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NB-1:0] issue_sel,
  output logic [NB-1:0] busy
);
  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
      if (!rst_n)                cnt_q <= '0;
      else if (issue_sel[b])     cnt_q <= CNT_W'(LAT - 1);
      else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
    end

    assign busy[b] = (cnt_q != '0);

    // R4
    bank_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
      issue_sel[b] |-> (cnt_q == '0));
  end
endmodule

// File: rtl/vagu_rsp_merge.sv
`timescale 1ns/1ps
module vagu_rsp_merge #(
  parameter int NB     = 4,
  parameter int DATA_W = 32,
  parameter int TAG_W  = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NB-1:0]        rsp_valid,
  input  logic [NB*DATA_W-1:0] rsp_data,
  input  logic [NB*TAG_W-1:0]  rsp_tag,
  output logic                 wb_valid,
  output logic [TAG_W-1:0]     wb_idx,
  output logic [DATA_W-1:0]    wb_data
);
  logic              any_c;
  logic [DATA_W-1:0] data_c;
  logic [TAG_W-1:0]  tag_c;

  always_comb begin
    any_c  = 1'b0;
    data_c = '0;
    tag_c  = '0;
    for (int b = 0; b < NB; b++) begin
      if (rsp_valid[b]) begin
        any_c  = 1'b1;
        data_c = rsp_data[b*DATA_W +: DATA_W];
        tag_c  = rsp_tag[b*TAG_W +: TAG_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wb_valid <= 1'b0;
      wb_idx   <= '0;
      wb_data  <= '0;
    end else begin
      wb_valid <= any_c;
      if (any_c) begin
        wb_idx  <= tag_c;
        wb_data <= data_c;
      end
    end
  end

  // R7
  rsp_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rsp_valid));
  // R7
  wb_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|rsp_valid) |=> wb_valid);
endmodule

// File: rtl/vec_agu.sv
`timescale 1ns/1ps
module vec_agu #(
  parameter int NB     = 4,
  parameter int LAT    = 4,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int MAX_VL = 16,
  localparam int TAG_W  = $clog2(MAX_VL),
  localparam int LEN_W  = $clog2(MAX_VL + 1),
  localparam int BSEL_W = $clog2(NB),
  localparam int ROW_W  = ADDR_W - BSEL_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cmd_valid,
  output logic                     cmd_ready,
  input  logic                     cmd_indexed,
  input  logic                     cmd_store,
  input  logic [ADDR_W-1:0]        cmd_base,
  input  logic [ADDR_W-1:0]        cmd_stride,
  input  logic [LEN_W-1:0]         cmd_len,
  input  logic [MAX_VL*ADDR_W-1:0] idx_vec,
  input  logic                     wd_valid,
  output logic                     wd_ready,
  input  logic [DATA_W-1:0]        wd_data,
  output logic [NB-1:0]            bank_sel,
  output logic                     bus_we,
  output logic [ROW_W-1:0]         bus_row,
  output logic [DATA_W-1:0]        bus_wdata,
  output logic [TAG_W-1:0]         bus_tag,
  input  logic [NB-1:0]            bank_rsp_valid,
  input  logic [NB*DATA_W-1:0]     bank_rsp_data,
  input  logic [NB*TAG_W-1:0]      bank_rsp_tag,
  output logic                     ld_valid,
  output logic [TAG_W-1:0]         ld_idx,
  output logic [DATA_W-1:0]        ld_data,
  output logic                     done
);
  import vagu_pkg::*;

  vagu_state_e       state_q;
  logic [TAG_W-1:0]  elem_q;
  logic [LEN_W-1:0]  len_q;
  logic [LEN_W-1:0]  pend_q;
  logic              store_q;
  logic              done_q;

  logic              accept;
  logic              fire;
  logic              last_elem;
  logic              bank_free;
  logic [ADDR_W-1:0] addr;
  logic [BSEL_W-1:0] bank;
  logic [NB-1:0]     busy;

  assign cmd_ready = (state_q == ST_IDLE);
  assign accept    = cmd_valid && cmd_ready;

  vagu_addr_gen #(.ADDR_W(ADDR_W), .MAX_VL(MAX_VL)) i_addr_gen (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (accept),
    .step    (fire),
    .indexed (cmd_indexed),
    .base    (cmd_base),
    .stride  (cmd_stride),
    .offsets (idx_vec),
    .elem    (elem_q),
    .addr    (addr)
  );

  assign bank      = addr[BSEL_W-1:0];
  assign bank_free = !busy[bank];
  assign fire      = (state_q == ST_RUN) && bank_free && (!store_q || wd_valid);
  assign wd_ready  = (state_q == ST_RUN) && store_q && bank_free;
  assign last_elem = ({1'b0, elem_q} == (len_q - LEN_W'(1)));

  assign bank_sel  = fire ? (NB'(1) << bank) : '0;
  assign bus_we    = store_q;
  assign bus_row   = addr[ADDR_W-1:BSEL_W];
  assign bus_wdata = wd_data;
  assign bus_tag   = elem_q;

  vagu_bank_busy #(.NB(NB), .LAT(LAT)) i_bank_busy (
    .clk       (clk),
    .rst_n     (rst_n),
    .issue_sel (bank_sel),
    .busy      (busy)
  );

  vagu_rsp_merge #(.NB(NB), .DATA_W(DATA_W), .TAG_W(TAG_W)) i_rsp_merge (
    .clk       (clk),
    .rst_n     (rst_n),
    .rsp_valid (bank_rsp_valid),
    .rsp_data  (bank_rsp_data),
    .rsp_tag   (bank_rsp_tag),
    .wb_valid  (ld_valid),
    .wb_idx    (ld_idx),
    .wb_data   (ld_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      elem_q  <= '0;
      len_q   <= '0;
      store_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          store_q <= cmd_store;
          len_q   <= cmd_len;
          elem_q  <= '0;
          state_q <= (cmd_len == '0) ? ST_WAIT : ST_RUN;
        end
        ST_RUN: if (fire) begin
          elem_q <= elem_q + 1'b1;
          if (last_elem) state_q <= ST_WAIT;
        end
        ST_WAIT: if (pend_q == '0) begin
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_q + LEN_W'(fire && !store_q) - LEN_W'(|bank_rsp_valid);
  end

  assign done = done_q;

  // R3
  one_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_sel));
  // R6
  store_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|bank_sel) && bus_we) |-> (wd_valid && wd_ready));
  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (bank_sel == '0));
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R3
  tag_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|bank_sel) && !last_elem) |=> (bus_tag == $past(bus_tag) + 1'b1));
endmodule

// File: tb/test_vec_agu.sv
`timescale 1ns/1ps
module test_vec_agu;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 4, LAT = 4, ADDR_W = 16, DATA_W = 32, MAX_VL = 16;
  localparam int TAG_W = 4, LEN_W = 5, ROW_W = 14;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic                     cmd_valid = 0, cmd_ready, cmd_indexed = 0, cmd_store = 0;
  logic [ADDR_W-1:0]        cmd_base = 0, cmd_stride = 0;
  logic [LEN_W-1:0]         cmd_len = 0;
  logic [MAX_VL*ADDR_W-1:0] idx_vec = '0;
  logic                     wd_valid = 0, wd_ready;
  logic [DATA_W-1:0]        wd_data = 0;
  logic [NB-1:0]            bank_sel;
  logic                     bus_we;
  logic [ROW_W-1:0]         bus_row;
  logic [DATA_W-1:0]        bus_wdata;
  logic [TAG_W-1:0]         bus_tag;
  logic [NB-1:0]            bank_rsp_valid = '0;
  logic [NB*DATA_W-1:0]     bank_rsp_data = '0;
  logic [NB*TAG_W-1:0]      bank_rsp_tag = '0;
  logic                     ld_valid, done;
  logic [TAG_W-1:0]         ld_idx;
  logic [DATA_W-1:0]        ld_data;

  vec_agu i_vec_agu (.*);

  int errors = 0, checks = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [DATA_W-1:0] mem [256];
  logic [DATA_W-1:0] ref_mem [256];
  int n_iss, n_ld, done_n, done_cyc, spacing_err, beat, starve_until;
  bit wd_on = 0;
  logic [DATA_W-1:0] wd_base = 0;
  int iss_cyc [64], iss_bank [64], iss_row [64], iss_tag [64];
  bit iss_we [64];
  logic [DATA_W-1:0] iss_wd [64];
  logic [DATA_W-1:0] got [16];
  int lastb [NB];
  bit pv = 0; int pb = 0; logic [DATA_W-1:0] pdata = 0; logic [TAG_W-1:0] ptag = 0;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // bank model (1-cycle response) and store-data source, then observation
  always @(negedge clk) begin
    bank_rsp_valid = '0;
    bank_rsp_data  = '0;
    bank_rsp_tag   = '0;
    if (pv) begin
      bank_rsp_valid[pb] = 1'b1;
      bank_rsp_data[pb*DATA_W +: DATA_W] = pdata;
      bank_rsp_tag[pb*TAG_W +: TAG_W] = ptag;
    end
    wd_valid = wd_on && (cyc >= starve_until);
    wd_data  = wd_base + DATA_W'(beat);
    #1;
    pv = 1'b0;
    if (rst_n) begin
      if (|bank_sel) begin
        int b, a;
        b = 0;
        for (int k = 0; k < NB; k++) if (bank_sel[k]) b = k;
        a = (int'(bus_row) * NB + b) & 255;
        if (n_iss < 64) begin
          iss_cyc[n_iss] = cyc; iss_bank[n_iss] = b; iss_row[n_iss] = int'(bus_row);
          iss_tag[n_iss] = int'(bus_tag); iss_we[n_iss] = bus_we; iss_wd[n_iss] = bus_wdata;
        end
        if (cyc - lastb[b] < LAT) spacing_err++;
        lastb[b] = cyc;
        if (bus_we) mem[a] = bus_wdata;
        else begin pv = 1'b1; pb = b; pdata = mem[a]; ptag = bus_tag; end
        n_iss++;
      end
      if (wd_valid && wd_ready) beat++;
      if (ld_valid) begin got[ld_idx] = ld_data; n_ld++; end
      if (done) begin done_n++; done_cyc = cyc; end
    end
  end

  task automatic run_cmd(input bit ind, input bit st, input logic [15:0] base,
                         input logic [15:0] stride, input int len, input int starve);
    logic [15:0] ea [16];
    int ecyc [16];
    int lastm [NB];
    int start, waitn, t, b;
    string areq;
    areq = ind ? "R2" : "R1";
    for (int i = 0; i < len; i++)
      ea[i] = ind ? base + idx_vec[i*16 +: 16] : base + 16'(i * int'(stride));
    for (int k = 0; k < NB; k++) lastm[k] = -1000;
    n_iss = 0; n_ld = 0; done_n = 0; spacing_err = 0; beat = 0;
    for (int i = 0; i < 16; i++) got[i] = '0;
    wd_base = 32'hD000_0000 + DATA_W'(cyc << 8);
    @(negedge clk);
    cmd_valid = 1; cmd_indexed = ind; cmd_store = st; cmd_base = base;
    cmd_stride = stride; cmd_len = LEN_W'(len);
    starve_until = cyc + 1 + starve; wd_on = st;
    @(negedge clk);
    start = cyc; cmd_valid = 0;
    chk("R9", "cmd_ready while busy", cmd_ready, 0);
    waitn = 0;
    while (done_n == 0 && waitn < 400) begin @(negedge clk); waitn++; end
    #2;
    wd_on = 0;
    for (int i = 0; i < len; i++) begin
      b = int'(ea[i][1:0]);
      t = (i == 0) ? start : ecyc[i-1] + 1;
      if (st && t < start + starve) t = start + starve;
      if (t < lastm[b] + LAT) t = lastm[b] + LAT;
      ecyc[i] = t; lastm[b] = t;
    end
    chk("R3", "request count", n_iss, len);
    chk("R4", "bank spacing violations", spacing_err, 0);
    for (int i = 0; i < len && i < n_iss; i++) begin
      chk(areq, $sformatf("bank of element %0d", i), iss_bank[i], ea[i][1:0]);
      chk(areq, $sformatf("row of element %0d", i), iss_row[i], ea[i][15:2]);
      chk("R3", $sformatf("tag of request %0d", i), iss_tag[i], i);
      chk("R5", $sformatf("issue cycle of element %0d", i), iss_cyc[i] - start, ecyc[i] - start);
      chk("R6", $sformatf("write enable of element %0d", i), iss_we[i], st);
      if (st) chk("R6", $sformatf("store data of element %0d", i), iss_wd[i], wd_base + DATA_W'(i));
    end
    if (!st) begin
      chk("R7", "writeback count", n_ld, len);
      for (int i = 0; i < len; i++)
        chk("R7", $sformatf("load data of element %0d", i), got[i], ref_mem[ea[i][7:0]]);
    end else begin
      for (int i = 0; i < len; i++) ref_mem[ea[i][7:0]] = wd_base + DATA_W'(i);
    end
    chk("R8", "done pulses", done_n, 1);
    if (len == 0) chk("R9", "done cycle for empty command", done_cyc - start, 1);
    else chk("R8", "done cycle", done_cyc - start, ecyc[len-1] - start + (st ? 2 : 3));
    repeat (LAT + 2) @(negedge clk);
    chk("R8", "single done pulse", done_n, 1);
  endtask

  task automatic test_reset;
    @(negedge clk);
    chk("R10", "cmd_ready in reset", cmd_ready, 1);
    chk("R10", "bank_sel in reset", bank_sel, 0);
    chk("R10", "done in reset", done, 0);
    chk("R10", "ld_valid in reset", ld_valid, 0);
  endtask

  task automatic test_unit_stride;   run_cmd(0, 1, 16'h0020, 16'd1, 8, 0); run_cmd(0, 0, 16'h0020, 16'd1, 8, 0); endtask
  task automatic test_stride_two;    run_cmd(0, 1, 16'h0040, 16'd2, 6, 0); run_cmd(0, 0, 16'h0040, 16'd2, 6, 0); endtask
  task automatic test_same_bank;     run_cmd(0, 1, 16'h0081, 16'd4, 4, 0); endtask
  task automatic test_coprime;       run_cmd(0, 0, 16'h0090, 16'd3, 8, 0); endtask
  task automatic test_wrap_down;     run_cmd(0, 0, 16'h0001, 16'hFFFF, 4, 0); endtask
  task automatic test_starved_store; run_cmd(0, 1, 16'h00A0, 16'd1, 3, 5); endtask
  task automatic test_empty;         run_cmd(0, 1, 16'h0000, 16'd1, 0, 0); endtask

  task automatic test_gather;
    idx_vec = '0;
    idx_vec[0*16 +: 16] = 16'd5;  idx_vec[1*16 +: 16] = 16'd0;
    idx_vec[2*16 +: 16] = 16'd9;  idx_vec[3*16 +: 16] = 16'd2;
    idx_vec[4*16 +: 16] = 16'd13; idx_vec[5*16 +: 16] = 16'd6;
    run_cmd(1, 0, 16'h0020, 16'd0, 6, 0);
  endtask

  task automatic test_scatter;
    idx_vec = '0;
    idx_vec[0*16 +: 16] = 16'd0; idx_vec[1*16 +: 16] = 16'd4;
    idx_vec[2*16 +: 16] = 16'd8; idx_vec[3*16 +: 16] = 16'd1;
    run_cmd(1, 1, 16'h00C0, 16'd0, 4, 0);
    run_cmd(1, 0, 16'h00C0, 16'd0, 4, 0);
  endtask

  initial begin
    for (int a = 0; a < 256; a++) begin
      mem[a] = 32'h5500_0000 + DATA_W'(a);
      ref_mem[a] = 32'h5500_0000 + DATA_W'(a);
    end
    for (int k = 0; k < NB; k++) lastb[k] = -1000;
    starve_until = 0;
    repeat (3) @(posedge clk);
    test_reset;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R10", "cmd_ready after reset", cmd_ready, 1);
    test_unit_stride;
    test_stride_two;
    test_same_bank;
    test_coprime;
    test_wrap_down;
    test_starved_store;
    test_empty;
    test_gather;
    test_scatter;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule